// File: doc/BRIEF.md
# Network Controller Command/Status Register Pair

This block is the host-visible command/status register pair of an Ethernet controller. A 16-bit status word collects events raised by the controller's internal units: a command completing, a frame arriving, the command unit going inactive, the receiver losing its ready state, a management-bus cycle finishing, a flow-control pause, and a software-requested interrupt. Each event bit is sticky. The host clears it by writing a one to that bit. The same word also reports the live state of the command unit and of the receive unit, as the controller supplies it.

The 16-bit command word carries a global interrupt mask, a software-interrupt request, and two operation fields, one for the command unit and one for the receive unit. A write to the command word turns each field into a one-cycle strobe for the matching unit. The field then goes back to no-operation. The interrupt output is the OR of all event bits, gated by the mask.

Top module: `ctl_csr`

## Requirements
- R1: After reset, every event bit of `stat_o` is 0, `cmd_o` is 0, every strobe is 0 and `irq_o` is 0.
- R2: An event input that is high at a clock edge sets its status bit from the next cycle on, and the bit stays set. The positions are: command done = bit 15, frame received = bit 14, command unit inactive = bit 13, receiver not ready = bit 12, management cycle done = bit 11, software interrupt = bit 10, flow-control pause = bit 8.
- R3: A status write clears every event bit (mask 0xFD00) whose write-data bit is 1. An event bit written with 0 keeps its value. Write data in bits 9 and 7:0 has no effect.
- R4: If an event input and the acknowledge of that same bit occur in the same cycle, the bit stays set.
- R5: `stat_o[7:6]` always equals `cu_state_i`, and `stat_o[5:2]` always equals `ru_state_i`. Receive-unit state codes are idle=0, suspended=1, no resources=2 and ready=4, with bit 3 added for the no-descriptor variants. Status bits 9, 1 and 0 always read 0.
- R6: A command write takes the command-unit code from `cmd_wdata_i[7:4]`. The codes are 1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base address, 7 dump and reset statistics. In the cycle after the write, the matching strobe is high for exactly one cycle and `cmd_o[7:4]` shows the code. One cycle later the field reads 0.
- R7: A command write takes the receive-unit code from `cmd_wdata_i[2:0]`. The codes are 1 start, 2 resume, 4 abort, 6 load base address, 7 resume with no resources. The matching strobe is high for exactly the one cycle after the write. The field then reads 0, except for code 6.
- R8: Receive code 6 stays in `cmd_o[2:0]` until the next command write, but its strobe pulses only once.
- R9: Any code not listed (command unit 0, 3 and 8 to 15; receive unit 0, 3 and 5) raises no strobe, and the field reads 0 after one cycle.
- R10: `cmd_wdata_i[8]` is stored as the interrupt mask and reads back in `cmd_o[8]`. All other command bits outside the two fields read 0.
- R11: A command write with bit 9 set raises the software-interrupt event (status bit 10) in the next cycle. `cmd_o[9]` reads 0.
- R12: `irq_o` is 1 exactly when some event bit is set and the mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_we_i | input | 1 | Status word write (acknowledge) strobe |
| stat_wdata_i | input | 16 | Status write data, ones clear event bits |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 16 | Command write data |
| ev_cmd_done_i | input | 1 | Command unit finished a command |
| ev_frame_rx_i | input | 1 | Frame received |
| ev_cu_idle_i | input | 1 | Command unit left its active state |
| ev_ru_stall_i | input | 1 | Receive unit left its ready state |
| ev_mgmt_done_i | input | 1 | Management read/write cycle done |
| ev_fc_pause_i | input | 1 | Flow-control pause event |
| cu_state_i | input | 2 | Live command-unit state |
| ru_state_i | input | 4 | Live receive-unit state |
| stat_o | output | 16 | Status word readback |
| cmd_o | output | 16 | Command word readback |
| cu_start_o | output | 1 | Command unit start strobe |
| cu_resume_o | output | 1 | Command unit resume strobe |
| cu_stats_addr_o | output | 1 | Load statistics address strobe |
| cu_stats_dump_o | output | 1 | Dump statistics strobe |
| cu_base_load_o | output | 1 | Command unit base address load strobe |
| cu_dump_reset_o | output | 1 | Dump and reset statistics strobe |
| ru_start_o | output | 1 | Receive unit start strobe |
| ru_resume_o | output | 1 | Receive unit resume strobe |
| ru_abort_o | output | 1 | Receive unit abort strobe |
| ru_base_load_o | output | 1 | Receive unit base address load strobe |
| ru_resume_nr_o | output | 1 | Receive resume with no resources strobe |
| irq_o | output | 1 | Maskable interrupt request |

## Verification
The hardest case to reach from the ports is an event input landing in the same edge as a host acknowledge of that bit. A second hard case is a held receive base-load code that must not pulse again while it sits in the field. The stimulus drives the event pulse and a status write with that bit set in one cycle, for every event position. It also steps several idle cycles after a code-6 write, checking that the strobe stays low while the field holds, and only then issues a fresh command write. Every command-unit and receive-unit code value is swept, and each expected strobe is worked out from the code map.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int unsigned N_EVT = 7;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] EVT_MASK = 16'hFD00;

  typedef enum logic [3:0] {
    CU_NOP = 4'd0, CU_START = 4'd1, CU_RESUME = 4'd2, CU_STATS_ADDR = 4'd4,
    CU_STATS_DUMP = 4'd5, CU_BASE = 4'd6, CU_DUMP_RST = 4'd7
  } cu_op_e;

  typedef enum logic [2:0] {
    RU_NOP = 3'd0, RU_START = 3'd1, RU_RESUME = 3'd2, RU_ABORT = 3'd4,
    RU_BASE = 3'd6, RU_RESUME_NR = 3'd7
  } ru_op_e;

  // internal event index -> status bit position (index 0 is the pause event)
  function automatic int unsigned evt_pos(int unsigned idx);
    return (idx == 0) ? 8 : idx + 9;
  endfunction
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // new event beats acknowledge
      else if (ack_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_field.sv
module cmd_field #(
  parameter int unsigned CU_W = 4,
  parameter int unsigned RU_W = 3,
  parameter logic [RU_W-1:0] RU_HOLD = 3'd6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            mask_i,
  input  logic [CU_W-1:0] cu_i,
  input  logic [RU_W-1:0] ru_i,
  output logic            mask_o,
  output logic            fresh_o,
  output logic [CU_W-1:0] cu_o,
  output logic [RU_W-1:0] ru_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= 1'b0;
      fresh_o <= 1'b0;
      cu_o    <= '0;
      ru_o    <= '0;
    end else begin
      fresh_o <= we_i;
      if (we_i) begin
        mask_o <= mask_i;
        cu_o   <= cu_i;
        ru_o   <= ru_i;
      end else if (fresh_o) begin
        cu_o <= '0;
        if (ru_o != RU_HOLD) ru_o <= '0;
      end
    end
  end
endmodule

// File: rtl/ctl_csr.sv
module ctl_csr
  import csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stat_we_i,
  input  logic [15:0] stat_wdata_i,
  input  logic        cmd_we_i,
  input  logic [15:0] cmd_wdata_i,
  input  logic        ev_cmd_done_i,
  input  logic        ev_frame_rx_i,
  input  logic        ev_cu_idle_i,
  input  logic        ev_ru_stall_i,
  input  logic        ev_mgmt_done_i,
  input  logic        ev_fc_pause_i,
  input  logic [1:0]  cu_state_i,
  input  logic [3:0]  ru_state_i,
  output logic [15:0] stat_o,
  output logic [15:0] cmd_o,
  output logic        cu_start_o,
  output logic        cu_resume_o,
  output logic        cu_stats_addr_o,
  output logic        cu_stats_dump_o,
  output logic        cu_base_load_o,
  output logic        cu_dump_reset_o,
  output logic        ru_start_o,
  output logic        ru_resume_o,
  output logic        ru_abort_o,
  output logic        ru_base_load_o,
  output logic        ru_resume_nr_o,
  output logic        irq_o
);
  logic [N_EVT-1:0] ev_set, ev_ack, ev_q;
  logic             si_req, mask_q, fresh_q;
  logic [3:0]       cu_q;
  logic [2:0]       ru_q;

  assign si_req = cmd_we_i & cmd_wdata_i[9];
  assign ev_set = {ev_cmd_done_i, ev_frame_rx_i, ev_cu_idle_i, ev_ru_stall_i,
                   ev_mgmt_done_i, si_req, ev_fc_pause_i};

  for (genvar i = 0; i < N_EVT; i++) begin : g_ack
    assign ev_ack[i] = stat_we_i & stat_wdata_i[evt_pos(i)];
  end

  evt_latch #(.N(N_EVT)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_set),
    .ack_i (ev_ack),
    .q_o   (ev_q)
  );

  cmd_field #(.CU_W(4), .RU_W(3), .RU_HOLD(RU_BASE)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cmd_we_i),
    .mask_i (cmd_wdata_i[8]),
    .cu_i   (cmd_wdata_i[7:4]),
    .ru_i   (cmd_wdata_i[2:0]),
    .mask_o (mask_q),
    .fresh_o(fresh_q),
    .cu_o   (cu_q),
    .ru_o   (ru_q)
  );

  always_comb begin
    stat_o = {8'h00, cu_state_i, ru_state_i, 2'b00};
    for (int unsigned i = 0; i < N_EVT; i++) stat_o[evt_pos(i)] = ev_q[i];
  end

  assign cmd_o = {7'b0, mask_q, cu_q, 1'b0, ru_q};

  // strobes only in the cycle right after a command write
  assign cu_start_o      = fresh_q && (cu_q == CU_START);
  assign cu_resume_o     = fresh_q && (cu_q == CU_RESUME);
  assign cu_stats_addr_o = fresh_q && (cu_q == CU_STATS_ADDR);
  assign cu_stats_dump_o = fresh_q && (cu_q == CU_STATS_DUMP);
  assign cu_base_load_o  = fresh_q && (cu_q == CU_BASE);
  assign cu_dump_reset_o = fresh_q && (cu_q == CU_DUMP_RST);
  assign ru_start_o      = fresh_q && (ru_q == RU_START);
  assign ru_resume_o     = fresh_q && (ru_q == RU_RESUME);
  assign ru_abort_o      = fresh_q && (ru_q == RU_ABORT);
  assign ru_base_load_o  = fresh_q && (ru_q == RU_BASE);
  assign ru_resume_nr_o  = fresh_q && (ru_q == RU_RESUME_NR);

  assign irq_o = (|ev_q) & ~mask_q;
endmodule

// File: rtl/ctl_csr_chk.sv
module ctl_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        stat_we_i,
  input logic [15:0] stat_wdata_i,
  input logic        cmd_we_i,
  input logic [15:0] cmd_wdata_i,
  input logic        ev_cmd_done_i,
  input logic        ev_frame_rx_i,
  input logic        ev_mgmt_done_i,
  input logic [1:0]  cu_state_i,
  input logic [3:0]  ru_state_i,
  input logic [15:0] stat_o,
  input logic [15:0] cmd_o,
  input logic        cu_start_o,
  input logic        cu_resume_o,
  input logic        cu_stats_addr_o,
  input logic        cu_stats_dump_o,
  input logic        cu_base_load_o,
  input logic        cu_dump_reset_o,
  input logic        ru_start_o,
  input logic        ru_resume_o,
  input logic        ru_abort_o,
  input logic        ru_base_load_o,
  input logic        ru_resume_nr_o,
  input logic        irq_o
);
  // R2
  ev_sets_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_frame_rx_i |=> stat_o[14]);
  // R3
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && stat_wdata_i[15] && !ev_cmd_done_i |=> !stat_o[15]);
  // R3
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[11] && !(stat_we_i && stat_wdata_i[11]) |=> stat_o[11]);
  // R5
  state_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[7:2] == {cu_state_i, ru_state_i});
  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cu_start_o && !cmd_we_i |=> !cu_start_o);
  // R6
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cu_start_o, cu_resume_o, cu_stats_addr_o, cu_stats_dump_o,
              cu_base_load_o, cu_dump_reset_o}) &&
    $onehot0({ru_start_o, ru_resume_o, ru_abort_o, ru_base_load_o, ru_resume_nr_o}));
  // R8
  ru_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ru_base_load_o && !cmd_we_i |=> (cmd_o[2:0] == 3'd6) && !ru_base_load_o);
  // R11
  swi_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_wdata_i[9] |=> stat_o[10]);
  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((|(stat_o & 16'hFD00)) && !cmd_o[8]));
endmodule

bind ctl_csr ctl_csr_chk u_chk (.*);

// File: tb/sim_ctl_csr.sv
`timescale 1ns/1ps
module sim_ctl_csr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stat_we = 0, cmd_we = 0;
  logic [15:0] stat_wd = '0, cmd_wd = '0;
  logic [6:0] ev = '0;  // index = internal event order, see ev_pos
  logic [1:0] cu_st = '0;
  logic [3:0] ru_st = '0;
  logic [15:0] stat, cmd;
  logic cu_start, cu_resume, cu_sa, cu_sd, cu_base, cu_dr;
  logic ru_start, ru_resume, ru_abort, ru_base, ru_rnr, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  ctl_csr u0 (
    .clk_i(clk), .rst_ni(rst_n), .stat_we_i(stat_we), .stat_wdata_i(stat_wd),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .ev_cmd_done_i(ev[6]), .ev_frame_rx_i(ev[5]), .ev_cu_idle_i(ev[4]),
    .ev_ru_stall_i(ev[3]), .ev_mgmt_done_i(ev[2]), .ev_fc_pause_i(ev[0]),
    .cu_state_i(cu_st), .ru_state_i(ru_st), .stat_o(stat), .cmd_o(cmd),
    .cu_start_o(cu_start), .cu_resume_o(cu_resume), .cu_stats_addr_o(cu_sa),
    .cu_stats_dump_o(cu_sd), .cu_base_load_o(cu_base), .cu_dump_reset_o(cu_dr),
    .ru_start_o(ru_start), .ru_resume_o(ru_resume), .ru_abort_o(ru_abort),
    .ru_base_load_o(ru_base), .ru_resume_nr_o(ru_rnr), .irq_o(irq));

  // ev[1] is unused: the software event is raised through the command word
  function automatic int ev_pos(int i);
    return (i == 0) ? 8 : 9 + i;
  endfunction

  function automatic logic [5:0] cu_exp(int c);
    case (c)
      1: return 6'b000001; 2: return 6'b000010; 4: return 6'b000100;
      5: return 6'b001000; 6: return 6'b010000; 7: return 6'b100000;
      default: return 6'b0;
    endcase
  endfunction

  function automatic logic [4:0] ru_exp(int r);
    case (r)
      1: return 5'b00001; 2: return 5'b00010; 4: return 5'b00100;
      6: return 5'b01000; 7: return 5'b10000;
      default: return 5'b0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    stat_we = 0; cmd_we = 0; ev = '0;
  endtask

  task automatic clear_all();
    stat_we = 1; stat_wd = 16'hFFFF; cmd_we = 0; ev = '0; step(); idle();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    check("R1 stat", {16'h0, stat & 16'hFD00}, 32'h0);
    check("R1 cmd", {16'h0, cmd}, 32'h0);
    check("R1 irq/strobes", {20'h0, irq, cu_start, cu_resume, cu_sa, cu_sd, cu_base,
          cu_dr, ru_start, ru_resume, ru_abort, ru_base, ru_rnr}, 32'h0);
    rst_n = 1; step();

    // R5 state pass-through sweep
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 16; r++) begin
        cu_st = c[1:0]; ru_st = r[3:0]; #1;
        check("R5 state", {26'h0, stat[7:2]}, (c * 16) + r);
        check("R5 zero bits", {29'h0, stat[9], stat[1:0]}, 32'h0);
      end
    end
    cu_st = 2'd1; ru_st = 4'd12;

    // R2 / R3 / R4 / R12 per event, with and without mask
    for (int m = 0; m < 2; m++) begin
      cmd_we = 1; cmd_wd = {7'b0, m[0], 8'h00}; step(); idle();
      for (int i = 0; i < 7; i++) begin
        if (i == 1) begin cmd_we = 1; cmd_wd = {6'b0, 1'b1, m[0], 8'h00}; end  // R11
        else ev[i] = 1;
        step(); idle();
        check("R2 set", {16'h0, stat & 16'hFD00}, 32'h1 << ev_pos(i));
        check("R12 irq", {31'h0, irq}, {31'h0, ~m[0]});
        check("R10 mask", {31'h0, cmd[8]}, {31'h0, m[0]});
        check("R11 bit9 reads 0", {31'h0, cmd[9]}, 32'h0);
        // zero writes and ignored bits do not clear
        stat_we = 1; stat_wd = ~(16'h1 << ev_pos(i)) & 16'h02FF; step(); idle();
        check("R3 zero keeps", {16'h0, stat & 16'hFD00}, 32'h1 << ev_pos(i));
        // other-bit acknowledge does not clear
        stat_we = 1; stat_wd = 16'hFD00 & ~(16'h1 << ev_pos(i)); step(); idle();
        check("R3 other ack", {16'h0, stat & 16'hFD00}, 32'h1 << ev_pos(i));
        // R4 acknowledge racing a new event
        stat_we = 1; stat_wd = 16'h1 << ev_pos(i);
        if (i == 1) begin cmd_we = 1; cmd_wd = {6'b0, 1'b1, m[0], 8'h00}; end
        else ev[i] = 1;
        step(); idle();
        check("R4 set wins", {16'h0, stat & 16'hFD00}, 32'h1 << ev_pos(i));
        stat_we = 1; stat_wd = 16'h1 << ev_pos(i); step(); idle();
        check("R3 ack clears", {16'h0, stat & 16'hFD00}, 32'h0);
        check("R12 irq low", {31'h0, irq}, 32'h0);
      end
    end
    // R2 all at once, R12 with several bits
    cmd_we = 1; cmd_wd = 16'h0200; ev = 7'b1111101; step(); idle();
    check("R2 all", {16'h0, stat & 16'hFD00}, 32'hFD00);
    check("R12 multi", {31'h0, irq}, 32'h1);
    clear_all();

    // R6 / R9 command unit sweep
    for (int c = 0; c < 16; c++) begin
      cmd_we = 1; cmd_wd = {8'h00, c[3:0], 4'h0}; step(); idle();
      check("R6 strobe", {26'h0, cu_dr, cu_base, cu_sd, cu_sa, cu_resume, cu_start},
            {26'h0, cu_exp(c)});
      check("R6 field", {28'h0, cmd[7:4]}, c);
      check("R9 ru quiet", {27'h0, ru_rnr, ru_base, ru_abort, ru_resume, ru_start}, 32'h0);
      step();
      check("R6 one cycle", {26'h0, cu_dr, cu_base, cu_sd, cu_sa, cu_resume, cu_start}, 32'h0);
      check("R9 field nop", {28'h0, cmd[7:4]}, 32'h0);
    end

    // R7 / R8 / R9 receive unit sweep
    for (int r = 0; r < 8; r++) begin
      cmd_we = 1; cmd_wd = {13'h0, r[2:0]}; step(); idle();
      check("R7 strobe", {27'h0, ru_rnr, ru_base, ru_abort, ru_resume, ru_start},
            {27'h0, ru_exp(r)});
      check("R7 cu quiet", {26'h0, cu_dr, cu_base, cu_sd, cu_sa, cu_resume, cu_start}, 32'h0);
      for (int k = 0; k < 3; k++) begin
        step();
        check("R7 one cycle", {27'h0, ru_rnr, ru_base, ru_abort, ru_resume, ru_start}, 32'h0);
        check("R8 field", {29'h0, cmd[2:0]}, (r == 6) ? 32'd6 : 32'd0);
      end
      if (r == 6) begin
        cmd_we = 1; cmd_wd = 16'h0010; step(); idle();
        check("R8 released", {29'h0, cmd[2:0]}, 32'h0);
        check("R8 new strobe", {31'h0, cu_start}, 32'h1);
        step();
      end
    end

    // R6 + R7 combined write, mask set at the same time (R10)
    cmd_we = 1; cmd_wd = 16'h0174; step(); idle();
    check("R6 combined", {31'h0, cu_dr}, 32'h1);
    check("R7 combined", {31'h0, ru_abort}, 32'h1);
    check("R10 combined", {16'h0, cmd}, 32'h0174);
    step();
    check("R10 held", {16'h0, cmd}, 32'h0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule